// File: doc/BRIEF.md
# Video Memory Host Access Port

This block is the host-facing register window of a tile-based video processor. A host CPU has no direct path into video memory. It reaches that memory only through a few byte-wide registers, which are picked by a 3-bit select and strobed by separate read and write enables. The host first loads a 14-bit video address with two writes to the address register, high byte first. It then moves bytes through the data register. After each data access the address steps by 1, or by 32 when the stride bit of the control register is set.

The video memory is held inside the block. The general store has `2**MEM_AW` bytes and is mirrored across the 14-bit address space. A separate 32-byte palette store answers the page `0x3F00`–`0x3FFF`, and its entries `0x00` and `0x10` share one cell. Data reads of the general store are delayed by one access: each read returns a buffer byte and then refills the buffer from the current address. Palette reads return the stored byte at once.

A frame-end pulse sets a blank flag, which the host can read in the status register. The interrupt request output is the blank flag ANDed with the interrupt-enable bit of the control register. The byte-order tracker is a two-state machine with states `TOG_HI` and `TOG_LO`. An address write moves it from `TOG_HI` to `TOG_LO` and from `TOG_LO` back to `TOG_HI`. A status read sends it to `TOG_HI` from either state.

Top module: `vid_access_port`

## Requirements
- R1: After reset the video address is 0, the byte-order tracker is in `TOG_HI`, both control bits are 0, the blank flag is 0, `nmi_req` is 0 and the read buffer holds 0. `rdata` is 0 in every cycle where `rd_en` is low.
- R2: Writes to register select 6 load the address. The first write sets address bits 13:8 from `wdata[5:0]` and discards `wdata[7:6]`. The second write sets bits 7:0. Writes keep alternating between the two in that order.
- R3: A write to select 7 stores `wdata` at the current address. In the same edge the address advances by 1 when control bit 2 is 0, or by 32 when it is 1. Control is written through select 0: bit 2 is the stride and bit 7 is the interrupt enable.
- R4: The address is 14 bits wide and wraps from `0x3FFF` to `0x0000` when it advances.
- R5: A select 7 read of an address outside `0x3F00`–`0x3FFF` returns the buffer byte in the same cycle. The buffer is then loaded from the current address, and the address advances as in R3.
- R6: Addresses whose bits 13:8 equal `0x3F` use the palette store, indexed by address bits 4:0. Index `0x10` is the same cell as index `0x00`. A palette read returns the cell directly, leaves the buffer unchanged and advances the address.
- R7: A pulse on `frame_end` sets the blank flag. A select 2 read returns the flag in bit 7 and 0 in the other bits. That read clears the flag, unless `frame_end` is high in the same cycle, and returns the byte-order tracker to `TOG_HI`.
- R8: `nmi_req` equals the blank flag ANDed with control bit 7 in every cycle.
- R9: Addresses outside the palette page reach general-store cell `addr mod 2**MEM_AW`, with `MEM_AW` = 10 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 3 | Register select (0 control, 2 status, 6 address, 7 data) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| nmi_req | output | 1 | Interrupt request, flag AND enable |

## Verification
Read data is combinational, so the bench samples `rdata` 1 ns after it raises `rd_en` at a falling edge, within the same cycle. Register writes, address steps, buffer refills and the blank flag all change on the next rising edge. The bench checks their effects through the next access or at the following falling edge, which is exactly one register stage later. `nmi_req` is registered-flag logic, so it is checked at the falling edge after the pulse or control write that changes it. The bench's own model of the buffer delay means each buffered byte is expected exactly one data read after the read that loaded it.

// File: rtl/vap_pkg.sv
package vap_pkg;
    localparam int VA_W = 14;
    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_STAT = 3'd2;
    localparam logic [2:0] SEL_ADDR = 3'd6;
    localparam logic [2:0] SEL_DATA = 3'd7;
    localparam logic [5:0] PAL_PAGE = 6'h3F;
    localparam int PAL_N = 32;

    typedef enum logic {
        TOG_HI = 1'b0,
        TOG_LO = 1'b1
    } tog_e;
endpackage

// File: rtl/vap_addr_ctrl.sv
module vap_addr_ctrl
    import vap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_addr,
    input  logic            step_en,
    input  logic            step32,
    input  logic            clr_tog,
    input  logic [7:0]      wbyte,
    output logic [VA_W-1:0] vaddr
);
    localparam logic [VA_W-1:0] STEP_ONE = VA_W'(1);
    localparam logic [VA_W-1:0] STEP_ROW = VA_W'(32);

    tog_e            tog_q, tog_d;
    logic [VA_W-1:0] vaddr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= TOG_HI;
        else        tog_q <= tog_d;
    end

    // next-state logic
    always_comb begin
        tog_d = tog_q;
        if (clr_tog) begin
            tog_d = TOG_HI;
        end else if (ld_addr) begin
            unique case (tog_q)
                TOG_HI: tog_d = TOG_LO;
                TOG_LO: tog_d = TOG_HI;
            endcase
        end
    end

    // address register, loaded per state or stepped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
        end else if (ld_addr) begin
            unique case (tog_q)
                TOG_HI: vaddr_q[VA_W-1:8] <= wbyte[VA_W-9:0];
                TOG_LO: vaddr_q[7:0]      <= wbyte;
            endcase
        end else if (step_en) begin
            vaddr_q <= vaddr_q + (step32 ? STEP_ROW : STEP_ONE);
        end
    end

    assign vaddr = vaddr_q;

    a_r2_hi_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_addr && !clr_tog && tog_q == TOG_HI) |=>
            (vaddr[VA_W-1:8] == $past(wbyte[VA_W-9:0]) && tog_q == TOG_LO));
    a_r2_lo_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_addr && !clr_tog && tog_q == TOG_LO) |=>
            (vaddr[7:0] == $past(wbyte) && tog_q == TOG_HI));
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !ld_addr && !step32) |=> (vaddr == $past(vaddr) + STEP_ONE));
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !ld_addr && !step32 && vaddr == '1) |=> (vaddr == '0));
    a_r7_tog_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tog |=> (tog_q == TOG_HI));
endmodule

// File: rtl/vap_store.sv
module vap_store
    import vap_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VA_W-1:0] vaddr,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [7:0]      wbyte,
    output logic [7:0]      rd_byte
);
    localparam int DEPTH = 1 << MEM_AW;
    localparam int PIW   = $clog2(PAL_N);

    logic [7:0]        mem_q [DEPTH];
    logic [7:0]        pal_q [PAL_N];
    logic [7:0]        buf_q;
    logic              is_pal;
    logic [PIW-1:0]    pal_idx;
    logic [MEM_AW-1:0] mem_idx;
    logic [7:0]        mem_rd;

    assign is_pal  = (vaddr[VA_W-1:8] == PAL_PAGE);
    assign mem_idx = vaddr[MEM_AW-1:0];
    assign mem_rd  = mem_q[mem_idx];

    // the background entry of the upper half folds onto the lower half
    always_comb begin
        pal_idx = vaddr[PIW-1:0];
        if (pal_idx == PIW'(16)) pal_idx = '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (is_pal) pal_q[pal_idx] <= wbyte;
            else        mem_q[mem_idx] <= wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                buf_q <= '0;
        else if (rd_en && !is_pal) buf_q <= mem_rd;
    end

    assign rd_byte = is_pal ? pal_q[pal_idx] : buf_q;

    a_r6_pal_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_pal) |=> $stable(buf_q));
    a_r6_alias_cell: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_pal && vaddr[PIW-1:0] == PIW'(16)) |=> (pal_q[0] == $past(wbyte)));
    a_r5_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(buf_q));
endmodule

// File: rtl/vap_blank.sv
module vap_blank (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic stat_rd,
    input  logic nmi_en,
    output logic flag,
    output logic nmi_req
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (frame_end) flag_q <= 1'b1;
        else if (stat_rd)   flag_q <= 1'b0;
    end

    assign flag    = flag_q;
    assign nmi_req = flag_q & nmi_en;

    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> flag);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !frame_end) |=> !flag);
    a_r8_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !nmi_req);
endmodule

// File: rtl/vid_access_port.sv
module vid_access_port
    import vap_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       frame_end,
    output logic       nmi_req
);
    logic            step32_q, nmi_en_q;
    logic            ld_addr, data_wr, data_rd, stat_rd;
    logic [VA_W-1:0] vaddr;
    logic [7:0]      store_byte;
    logic            blank_flag;

    assign ld_addr = wr_en && sel == SEL_ADDR;
    assign data_wr = wr_en && sel == SEL_DATA;
    assign data_rd = rd_en && sel == SEL_DATA;
    assign stat_rd = rd_en && sel == SEL_STAT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step32_q <= 1'b0;
            nmi_en_q <= 1'b0;
        end else if (wr_en && sel == SEL_CTRL) begin
            step32_q <= wdata[2];
            nmi_en_q <= wdata[7];
        end
    end

    vap_addr_ctrl u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_addr (ld_addr),
        .step_en (data_wr || data_rd),
        .step32  (step32_q),
        .clr_tog (stat_rd),
        .wbyte   (wdata),
        .vaddr   (vaddr)
    );

    vap_store #(.MEM_AW(MEM_AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .vaddr   (vaddr),
        .wr_en   (data_wr),
        .rd_en   (data_rd),
        .wbyte   (wdata),
        .rd_byte (store_byte)
    );

    vap_blank u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .stat_rd   (stat_rd),
        .nmi_en    (nmi_en_q),
        .flag      (blank_flag),
        .nmi_req   (nmi_req)
    );

    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            unique case (sel)
                SEL_STAT: rdata = {blank_flag, 7'b0};
                SEL_DATA: rdata = store_byte;
                default:  rdata = 8'h00;
            endcase
        end
    end

    a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == 8'h00));
    a_r3_step_row: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_wr || data_rd) && step32_q) |=> (vaddr == $past(vaddr) + VA_W'(32)));
    a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_flag && nmi_en_q) |-> nmi_req);
endmodule

// File: tb/vid_access_port_bench.sv
`timescale 1ns/1ps
module vid_access_port_bench;
    localparam int MAW = 10;
    localparam int DEP = 1 << MAW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, frame_end = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       nmi_req;

    int total = 0, bad = 0;
    bit done = 0;

    logic [7:0]  mem_m [DEP];
    bit          known_m [DEP];
    logic [7:0]  pal_m [32];
    logic [7:0]  buf_m;
    bit          buf_known;
    logic [13:0] va_m;
    bit          step32_m;

    always #2.5 clk = ~clk;

    vid_access_port #(.MEM_AW(MAW)) u_vid_access_port (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .frame_end(frame_end), .nmi_req(nmi_req)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    function automatic bit in_pal(input logic [13:0] a);
        return a[13:8] == 6'h3F;
    endfunction

    function automatic int pidx(input logic [13:0] a);
        return (a[4:0] == 5'h10) ? 0 : int'(a[4:0]);
    endfunction

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] got);
        sel = s; rd_en = 1'b1;
        #1 got = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_ctrl(input logic [7:0] d);
        wr(3'd0, d);
        step32_m = d[2];
    endtask

    task automatic set_addr(input logic [13:0] a);
        wr(3'd6, {2'b00, a[13:8]});
        wr(3'd6, a[7:0]);
        va_m = a;
    endtask

    task automatic advance();
        va_m = va_m + (step32_m ? 14'd32 : 14'd1);
    endtask

    task automatic data_wr(input logic [7:0] d);
        wr(3'd7, d);
        if (in_pal(va_m)) pal_m[pidx(va_m)] = d;
        else begin
            mem_m[va_m[MAW-1:0]] = d;
            known_m[va_m[MAW-1:0]] = 1'b1;
        end
        advance();
    endtask

    task automatic data_rd(input string tag);
        logic [7:0] got;
        rd(3'd7, got);
        if (in_pal(va_m)) chk(tag, got, pal_m[pidx(va_m)]);
        else begin
            if (buf_known) chk(tag, got, buf_m);
            buf_m = mem_m[va_m[MAW-1:0]];
            buf_known = known_m[va_m[MAW-1:0]];
        end
        advance();
    endtask

    task automatic pulse_frame();
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        for (int i = 0; i < DEP; i++) known_m[i] = 1'b0;
        buf_m = 8'h00; buf_known = 1'b1; va_m = '0; step32_m = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports
        chk("R1 idle rdata", rdata, 8'h00);
        chk("R1 nmi", {7'b0, nmi_req}, 8'h00);
        rd(3'd2, got); chk("R1 status", got, 8'h00);
        data_rd("R1 buffer zero");

        // R3/R9: stride-1 fill of the whole store, read back through mirror
        set_addr(14'h0000);
        for (int i = 0; i < DEP; i++) data_wr(8'(i * 7 + 3) ^ 8'(i >> 8));
        set_addr(14'h0400);
        for (int i = 0; i <= DEP; i++) data_rd("R9 mirror readback");
        set_addr(14'h2C00);
        for (int i = 0; i < 40; i++) data_rd("R5 buffered read");

        // R2: high byte masking and byte order
        wr(3'd6, 8'hC1); wr(3'd6, 8'h23); va_m = 14'h0123;
        data_wr(8'hAA);
        set_addr(14'h0123);
        data_rd("R2 masked addr");
        data_rd("R2 masked addr");

        // R3: stride 32 writes and reads
        set_ctrl(8'h04);
        set_addr(14'h0005);
        for (int i = 0; i < 64; i++) data_wr(8'(8'h90 + i * 3));
        set_addr(14'h0005);
        for (int i = 0; i < 65; i++) data_rd("R3 stride32");
        set_ctrl(8'h00);

        // R6: palette fill and immediate read, alias of 0x00/0x10
        set_addr(14'h3F00);
        for (int i = 0; i < 32; i++) data_wr(8'(8'h40 + i * 5));
        set_addr(14'h3F00);
        for (int i = 0; i < 32; i++) data_rd("R6 palette");
        set_addr(14'h3F10); data_wr(8'hE7);
        set_addr(14'h3F00); data_rd("R6 alias 10->00");
        set_addr(14'h3FE0); data_rd("R6 alias mirror 00");

        // R4: wrap from 0x3FFF to 0
        set_addr(14'h3FFF);
        data_wr(8'h11);
        data_wr(8'h5C);
        set_addr(14'h0000);
        data_rd("R4 wrap");
        data_rd("R4 wrap");
        set_addr(14'h3FFF); data_rd("R4 wrap pal");

        // R7: status read resets byte order
        wr(3'd6, 8'h12);
        rd(3'd2, got); chk("R7 status idle", got, 8'h00);
        set_addr(14'h0200);
        data_wr(8'h3D);
        set_addr(14'h0200);
        data_rd("R7 toggle reset");
        data_rd("R7 toggle reset");

        // R7/R8: blank flag and interrupt
        pulse_frame();
        chk("R8 nmi disabled", {7'b0, nmi_req}, 8'h00);
        rd(3'd2, got); chk("R7 flag set", got, 8'h80);
        rd(3'd2, got); chk("R7 flag cleared", got, 8'h00);
        set_ctrl(8'h80);
        chk("R8 no flag", {7'b0, nmi_req}, 8'h00);
        pulse_frame();
        chk("R8 nmi raised", {7'b0, nmi_req}, 8'h01);
        rd(3'd2, got); chk("R7 flag read", got, 8'h80);
        chk("R8 nmi dropped", {7'b0, nmi_req}, 8'h00);
        pulse_frame();
        set_ctrl(8'h00);
        chk("R8 enable off", {7'b0, nmi_req}, 8'h00);
        set_ctrl(8'h80);
        chk("R8 enable on", {7'b0, nmi_req}, 8'h01);
        sel = 3'd2; rd_en = 1'b1; frame_end = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; frame_end = 1'b0;
        rd(3'd2, got); chk("R7 set beats clear", got, 8'h80);
        chk("R1 idle rdata late", rdata, 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule